// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous static memory. Its output is registered, and it runs short bursts of four words from one presented address. A cycle is opened by one of two active-low strobes. The processor-side strobe always opens a read and is gated by the primary chip enable. The controller-side strobe can open a read or a write, and it still acts when the primary enable is inactive: in that case it deselects the part. Once a burst is open, an active-low advance input steps a 2-bit counter. The counter runs in linear order or in interleaved (XOR) order within the aligned group of four words, as chosen by `linearOrder`.

Writes are done per 9-bit byte lane, each lane gated by its own strobe together with a byte write enable. A global write enable overrides the lane strobes and writes the full word. The data buses are split. Instead of a tri-state pad there is a drive flag, which says when the output would be driven.

Top module: `pipe_burst_sram`

## Requirements
- R1: An edge with `procStrobeN`=0 and `ceMainN`=0, while the part is selected (`ceMainN`=0, `ceAuxHi`=1, `ceAuxN`=0), opens a read burst at `addrIn`. The values of `globalWrN`, `byteWrEnN`, `laneWrN` and `ctrlStrobeN` do not matter on that edge.
- R2: A read access made on edge k places that word on `rdData` after edge k+1. If byte strobes are idle and `outEnN`=0, `rdDrive` is 1 from then on.
- R3: An edge with `procStrobeN`=0 and `ceMainN`=1 does nothing: there is no access and an open burst keeps its base. `ctrlStrobeN`=0 with `procStrobeN`=1 still takes effect when `ceMainN`=1.
- R4: The controller-side strobe opens a cycle only when `procStrobeN`=1 on that edge. On that edge the write controls choose between write and read.
- R5: `globalWrN`=0 writes all 18 bits, whatever `byteWrEnN` and `laneWrN` say.
- R6: With `globalWrN`=1, lane g (bits [9g+8:9g], `laneWrN[g]`) is written only when `byteWrEnN`=0 and `laneWrN[g]`=0.
- R7: Lane strobes and write enables are ignored on an edge that samples `procStrobeN`=0. Memory is left unchanged.
- R8: On an edge with `procStrobeN`=1, any `laneWrN` bit at 0 forces `rdDrive`=0 after that edge, whatever the value of `outEnN`.
- R9: `rdDrive` is 1 only when `outEnN`=0 and the data came from a burst opened while selected. A controller-strobe edge while not selected closes the burst.
- R10: On a continuation edge (both strobes 1, burst open) with `advanceN`=0, the counter steps and the access uses the next address. The low two address bits are base+count mod 4 when `linearOrder`=1 and base XOR count when it is 0.
- R11: Reset (`rstN`=0) clears `rdData` to 0 and `rdDrive` to 0.
- R12: `advanceN` is ignored on a burst-opening edge. The count starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| addrIn | input | ADDR_W | Address presented at burst start |
| ceMainN | input | 1 | Primary chip enable, active low |
| ceAuxHi | input | 1 | Secondary chip enable, active high |
| ceAuxN | input | 1 | Secondary chip enable, active low |
| procStrobeN | input | 1 | Processor-side start strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side start strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Full-word write, active low |
| byteWrEnN | input | 1 | Byte write enable, active low |
| laneWrN | input | 2 | Per-lane write strobes, active low |
| outEnN | input | 1 | Output enable, active low |
| linearOrder | input | 1 | 1 = linear burst order, 0 = interleaved |
| wrData | input | 2*LANE_W | Write data |
| rdData | output | 2*LANE_W | Registered read data |
| rdDrive | output | 1 | Output would be driven |

## Verification
The hardest case to reach is the edge where the processor strobe is low but blocked by the primary enable. From outside it must look like nothing happened, and this has to be told apart from a deselect. The stimulus opens a burst, sends the blocked strobe with a different address, and then shows two things: the drive drops for exactly one cycle, and the next continuation still returns the old base word. A controller-strobe deselect, by contrast, ends the burst. A second hard case is a byte strobe during a read burst with no write enabled: the bench checks that the drive falls while the stored data stays unchanged.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic       rdReq;    // read the access address this edge
    logic [1:0] laneWr;   // per-lane write this edge
    logic       laneOff;  // a lane strobe was sampled low
  } accessT;

  // Low two address bits of the current burst word.
  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic linear);
    return linear ? (base + cnt) : (base ^ cnt);
  endfunction

endpackage

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl
  import pbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ceMainN,
  input  logic              ceAuxHi,
  input  logic              ceAuxN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [1:0]        laneWrN,
  input  logic              linearOrder,
  output logic [ADDR_W-1:0] accAddr,
  output accessT            acc
);

  logic [ADDR_W-1:0] baseQ;
  logic [1:0]        cntQ;
  logic              activeQ;

  logic       selected, procStart, ctrlStart, anyStart, contEdge;
  logic [1:0] wrLanes, cntStep, cntUse;

  assign selected  = !ceMainN && ceAuxHi && !ceAuxN;
  assign procStart = !procStrobeN && !ceMainN;          // main enable gates proc strobe
  assign ctrlStart = procStrobeN && !ctrlStrobeN;       // proc strobe has priority
  assign anyStart  = procStart || ctrlStart;
  assign contEdge  = procStrobeN && ctrlStrobeN && activeQ;

  // Global write overrides per-lane strobes.
  assign wrLanes = !globalWrN ? 2'b11 : ({2{!byteWrEnN}} & ~laneWrN);

  assign cntStep = cntQ + 2'd1;
  assign cntUse  = advanceN ? cntQ : cntStep;

  always_comb begin
    acc     = '0;
    accAddr = {baseQ[ADDR_W-1:2], burstLow(baseQ[1:0], cntUse, linearOrder)};
    if (anyStart) begin
      accAddr = addrIn;
      if (selected) begin
        if (ctrlStart && (wrLanes != 2'b00)) acc.laneWr = wrLanes;
        else                                 acc.rdReq  = 1'b1;
      end
    end else if (contEdge) begin
      if (wrLanes != 2'b00) acc.laneWr = wrLanes;
      else                  acc.rdReq  = 1'b1;
    end
    acc.laneOff = procStrobeN && (laneWrN != 2'b11);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ   <= '0;
      cntQ    <= '0;
      activeQ <= 1'b0;
    end else if (anyStart) begin
      if (selected) begin
        baseQ   <= addrIn;
        cntQ    <= '0;
        activeQ <= 1'b1;
      end else begin
        activeQ <= 1'b0;
      end
    end else if (contEdge && !advanceN) begin
      cntQ <= cntStep;
    end
  end

endmodule

// File: rtl/pbsram_dp.sv
module pbsram_dp
  import pbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   accAddr,
  input  accessT              acc,
  input  logic [2*LANE_W-1:0] wrData,
  input  logic                outEnN,
  output logic [2*LANE_W-1:0] rdData,
  output logic                rdDrive
);

  localparam int WORD_W = 2 * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ADDR_W-1:0] rdAddrQ;
  logic              rdPendQ, validQ, laneOffQ;
  logic [WORD_W-1:0] dataQ, rdWord;

  for (genvar g = 0; g < 2; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (acc.laneWr[g]) laneMem[accAddr] <= wrData[g*LANE_W +: LANE_W];
    end
    assign rdWord[g*LANE_W +: LANE_W] = laneMem[rdAddrQ];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPendQ  <= 1'b0;
      rdAddrQ  <= '0;
      validQ   <= 1'b0;
      laneOffQ <= 1'b0;
      dataQ    <= '0;
    end else begin
      rdPendQ  <= acc.rdReq;
      rdAddrQ  <= accAddr;
      laneOffQ <= acc.laneOff;
      validQ   <= rdPendQ;
      if (rdPendQ) dataQ <= rdWord;
    end
  end

  assign rdData  = dataQ;
  assign rdDrive = validQ && !laneOffQ && !outEnN;

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import pbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic                ceMainN,
  input  logic                ceAuxHi,
  input  logic                ceAuxN,
  input  logic                procStrobeN,
  input  logic                ctrlStrobeN,
  input  logic                advanceN,
  input  logic                globalWrN,
  input  logic                byteWrEnN,
  input  logic [1:0]          laneWrN,
  input  logic                outEnN,
  input  logic                linearOrder,
  input  logic [2*LANE_W-1:0] wrData,
  output logic [2*LANE_W-1:0] rdData,
  output logic                rdDrive
);

  logic [ADDR_W-1:0] accAddr;
  accessT            acc;

  pbsram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .ceMainN(ceMainN), .ceAuxHi(ceAuxHi), .ceAuxN(ceAuxN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneWrN(laneWrN), .linearOrder(linearOrder),
    .accAddr(accAddr), .acc(acc)
  );

  pbsram_dp #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .acc(acc),
    .wrData(wrData), .outEnN(outEnN), .rdData(rdData), .rdDrive(rdDrive)
  );

endmodule

// File: rtl/pipe_burst_sram_chk.sv
module pipe_burst_sram_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ceMainN,
  input logic       ceAuxHi,
  input logic       ceAuxN,
  input logic       procStrobeN,
  input logic       ctrlStrobeN,
  input logic [1:0] laneWrN,
  input logic       outEnN,
  input logic       rdDrive
);

  // R8
  lane_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && (laneWrN != 2'b11)) |=> !rdDrive);

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !rdDrive);

  // R9
  deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && !ctrlStrobeN && ceMainN) |=> ##1 !rdDrive);

  // R3
  proc_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && ceMainN) |=> ##1 !rdDrive);

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !ceMainN && ceAuxHi && !ceAuxN) ##1 (laneWrN == 2'b11)
      |=> (rdDrive || outEnN));

endmodule

bind pipe_burst_sram pipe_burst_sram_chk chk_i (
  .clk(clk), .rstN(rstN), .ceMainN(ceMainN), .ceAuxHi(ceAuxHi),
  .ceAuxN(ceAuxN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
  .laneWrN(laneWrN), .outEnN(outEnN), .rdDrive(rdDrive)
);

// File: tb/pipe_burst_sram_tb_top.sv
module pipe_burst_sram_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  addrIn = '0;
  logic        ceMainN, ceAuxHi, ceAuxN, procStrobeN, ctrlStrobeN, advanceN;
  logic        globalWrN, byteWrEnN, outEnN, linearOrder;
  logic [1:0]  laneWrN;
  logic [17:0] wrData = '0;
  logic [17:0] rdData;
  logic        rdDrive;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pipe_burst_sram dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .ceMainN(ceMainN),
    .ceAuxHi(ceAuxHi), .ceAuxN(ceAuxN), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .globalWrN(globalWrN),
    .byteWrEnN(byteWrEnN), .laneWrN(laneWrN), .outEnN(outEnN),
    .linearOrder(linearOrder), .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive)
  );

  typedef struct packed {
    logic        procN;
    logic        ctrlN;
    logic        advN;
    logic        gwN;
    logic [5:0]  addr;
    logic [17:0] wdata;
    logic        expDrive;
    logic [17:0] expData;
    logic        chkData;
  } vecT;

  // Write burst 8..11 (ctrl strobe, global write), then read burst (R1, R2, R10, R12)
  localparam vecT VEC [0:10] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 6'd8, 18'h11111, 1'b0, 18'h0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 18'h22222, 1'b0, 18'h0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 18'h03333, 1'b0, 18'h0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 18'h04444, 1'b0, 18'h0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 6'd8, 18'h00000, 1'b0, 18'h0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'd0, 18'h0, 1'b1, 18'h11111, 1'b1},
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'd0, 18'h0, 1'b1, 18'h22222, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b1, 6'd0, 18'h0, 1'b1, 18'h03333, 1'b1},
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'd0, 18'h0, 1'b1, 18'h03333, 1'b1},
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'd0, 18'h0, 1'b1, 18'h04444, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b1, 6'd0, 18'h0, 1'b1, 18'h11111, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    globalWrN = 1'b1; byteWrEnN = 1'b1; laneWrN = 2'b11; outEnN = 1'b0;
    ceMainN = 1'b0; ceAuxHi = 1'b1; ceAuxN = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic procRd(input logic [5:0] a);
    idle(); procStrobeN = 1'b0; addrIn = a; tick();
  endtask

  task automatic ctrlWr(input logic [5:0] a, input logic [17:0] d);
    idle(); ctrlStrobeN = 1'b0; globalWrN = 1'b0; addrIn = a; wrData = d; tick();
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    idle();
    linearOrder = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 data", rdData, 18'h0);
    check("R11 drive", rdDrive, 1'b0);
    rstN = 1'b1;
    tick();
    check("R11 drive idle", rdDrive, 1'b0);

    for (int i = 0; i < 11; i++) begin
      idle();
      procStrobeN = VEC[i].procN; ctrlStrobeN = VEC[i].ctrlN;
      advanceN = VEC[i].advN; globalWrN = VEC[i].gwN;
      addrIn = VEC[i].addr; wrData = VEC[i].wdata;
      tick();
      check($sformatf("R2 R10 drive row%0d", i), rdDrive, VEC[i].expDrive);
      if (VEC[i].chkData) check($sformatf("R1 R10 R12 data row%0d", i), rdData, VEC[i].expData);
    end

    // R6: lane-only write, and a lane strobe without byte enable writes nothing
    ctrlWr(6'd20, 18'h0);
    idle(); ctrlStrobeN = 1'b0; byteWrEnN = 1'b0; laneWrN = 2'b10;
    wrData = 18'h3FFFF; addrIn = 6'd20; tick();
    idle(); ctrlStrobeN = 1'b0; laneWrN = 2'b01; wrData = 18'h3FFFF; addrIn = 6'd20; tick();
    check("R8 drive off after lane strobe", rdDrive, 1'b0);
    procRd(6'd20);
    idle(); tick();
    check("R6 lane0 only", rdData, 18'h001FF);
    check("R6 drive", rdDrive, 1'b1);

    // R5: global write overrides lane strobes
    idle(); ctrlStrobeN = 1'b0; globalWrN = 1'b0; laneWrN = 2'b00;
    addrIn = 6'd21; wrData = 18'h2AB55; tick();
    procRd(6'd21);
    idle(); tick();
    check("R5 full word", rdData, 18'h2AB55);

    // R8: lane strobe during read burst forces drive off despite outEnN=0
    idle(); laneWrN = 2'b01; tick();
    check("R8 drive forced off", rdDrive, 1'b0);
    idle(); tick();
    check("R8 drive back", rdDrive, 1'b1);
    check("R8 data kept", rdData, 18'h2AB55);

    // R7: write controls ignored on processor strobe edge
    idle(); procStrobeN = 1'b0; addrIn = 6'd21; byteWrEnN = 1'b0;
    laneWrN = 2'b00; globalWrN = 1'b0; wrData = 18'h0; tick();
    idle(); tick();
    check("R7 memory unchanged", rdData, 18'h2AB55);
    check("R7 drive", rdDrive, 1'b1);

    // R3: blocked processor strobe is a no-op, burst keeps its base
    procRd(6'd21);
    idle(); procStrobeN = 1'b0; ceMainN = 1'b1; addrIn = 6'd20; tick();
    idle(); tick();
    check("R3 no access on blocked edge", rdDrive, 1'b0);
    idle(); tick();
    check("R3 burst base kept", rdData, 18'h2AB55);
    check("R3 drive", rdDrive, 1'b1);

    // R9 / R3: controller strobe with main enable off deselects
    idle(); ctrlStrobeN = 1'b0; ceMainN = 1'b1; tick();
    idle(); tick();
    idle(); tick();
    check("R9 R3 deselected drive", rdDrive, 1'b0);

    // R9: output enable gates drive
    procRd(6'd21);
    idle(); outEnN = 1'b1; tick();
    check("R9 outEn off", rdDrive, 1'b0);
    outEnN = 1'b0; #1;
    check("R9 outEn on", rdDrive, 1'b1);

    // R4: processor strobe wins over controller strobe; ctrl-start read
    ctrlWr(6'd22, 18'h12345);
    idle(); procStrobeN = 1'b0; ctrlStrobeN = 1'b0; globalWrN = 1'b0;
    addrIn = 6'd22; wrData = 18'h0; tick();
    idle(); tick();
    check("R4 no write when proc low", rdData, 18'h12345);
    idle(); ctrlStrobeN = 1'b0; addrIn = 6'd20; tick();
    idle(); tick();
    check("R4 ctrl read", rdData, 18'h001FF);

    // R10 interleaved order from base 9: 9,8,11,10 (R12 advance on start ignored)
    linearOrder = 1'b0;
    idle(); procStrobeN = 1'b0; advanceN = 1'b0; addrIn = 6'd9; tick();
    idle(); advanceN = 1'b0; tick();
    check("R12 R10 word0", rdData, 18'h22222);
    idle(); advanceN = 1'b0; tick();
    check("R10 word1", rdData, 18'h11111);
    idle(); advanceN = 1'b0; tick();
    check("R10 word2", rdData, 18'h04444);
    idle(); tick();
    check("R10 word3", rdData, 18'h03333);

    finish();
  end

endmodule